// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes the processor state changes needed to take an exception. Two exception kinds are supported: a maskable interrupt request and a software-interrupt request raised by an instruction. When one of them is accepted, the block registers a complete entry bundle and pulses it for one cycle. The bundle holds the vector to branch to, the return address for the link register, a copy of the outgoing status word for the saved-status register, the new status word, and the mode code the register file must bank into. Along with the bundle, the block pulses a mode-change write enable and a pipeline flush. The flush makes the fetch stage reload its prefetch from the new PC.

The software-interrupt request uses a valid/ready handshake. The issuing stage raises `swi_valid` and holds it, together with `cur_pc` and `cur_status`, until it sees `swi_ready` high at a clock edge. That edge is the transfer. `swi_ready` goes low for exactly one cycle after every entry, because during that cycle the register file applies the new state. The interrupt request is a plain level. It is taken only while the interrupt-disable bit of `cur_status` is clear and the block is not blocked.

Status word fields used by this block:
- bit 7 is the interrupt-disable bit.
- bit 5 is the narrow-state bit: 1 means 2-byte instructions, 0 means 4-byte instructions.
- bits 4:0 are the mode field.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `ent_valid`, `mode_we` and `flush` are 0, every payload output is 0, and `swi_ready` is 1.
- R2: When `irq_req` is 1, status bit 7 is 0, no software interrupt transfers and the block is not blocked, the next cycle shows `ent_valid`=1, `ent_mode`=5'h12 and `ent_pc`=32'h18.
- R3: While status bit 7 is 1, `irq_req` produces no entry (`ent_valid` stays 0).
- R4: A software-interrupt transfer produces, one cycle later, `ent_valid`=1, `ent_mode`=5'h13 and `ent_pc`=32'h08, regardless of status bit 7.
- R5: For an interrupt entry, `ent_link` equals PC minus the instruction width plus 4, modulo 2^32.
- R6: For a software-interrupt entry, `ent_link` equals PC minus the instruction width, modulo 2^32. The width is 2 when status bit 5 is 1 and 4 when it is 0.
- R7: `ent_saved` equals the status word at acceptance. `ent_status` equals that word with bits 4:0 replaced by the entry mode, bit 7 set and bit 5 cleared.
- R8: When both requests occur in the same cycle, the software interrupt is taken. If `irq_req` is still 1 and unmasked once the block unblocks, the interrupt is taken then.
- R9: In the cycle following any entry, `swi_ready` is 0 and no entry is taken. A held software request transfers on the next edge.
- R10: `mode_we` and `flush` are 1 exactly in the cycles where `ent_valid` is 1. Each entry pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request level |
| swi_valid | input | 1 | Software-interrupt request valid |
| swi_ready | output | 1 | Software-interrupt request accepted when high with valid |
| cur_pc | input | 32 | Current program counter |
| cur_status | input | 32 | Current status word |
| ent_valid | output | 1 | Entry bundle valid (one-cycle pulse) |
| ent_pc | output | 32 | Vector address to branch to |
| ent_link | output | 32 | Return address for the link register |
| ent_saved | output | 32 | Value for the saved-status register |
| ent_status | output | 32 | New status word |
| ent_mode | output | 5 | Mode code to bank into |
| mode_we | output | 1 | Mode-change write to the register file |
| flush | output | 1 | Pipeline flush and prefetch reload |

## Verification
The assertions check the following on every cycle:
- the interrupt mask, the priority of a software transfer and the blocked cycle after an entry;
- that the vector matches the mode and the status bits are forced;
- that both return-address formulas hold against the sampled inputs.

Only the bench scenarios can show the following:
- that a pending interrupt is actually taken after the software interrupt;
- that a held software request is re-accepted once the block unblocks;
- that the arithmetic wraps correctly at the ends of the address range.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_IRQ  = 2'd1,
    KIND_SWI  = 2'd2
  } exc_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  logic      irq_req,
  input  logic      irq_mask,
  input  logic      swi_valid,
  input  logic      blocked,
  output logic      swi_ready,
  output exc_kind_e kind
);
  always_comb begin
    swi_ready = !blocked;
    kind      = KIND_NONE;
    if (!blocked) begin
      if (swi_valid)                 kind = KIND_SWI;
      else if (irq_req && !irq_mask) kind = KIND_IRQ;
    end
  end
endmodule

// File: rtl/exc_link_calc.sv
module exc_link_calc
  import exc_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int T_BIT = 5
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] status,
  input  exc_kind_e       kind,
  output logic [XLEN-1:0] link
);
  localparam logic [XLEN-1:0] WIDE_W   = XLEN'(4);
  localparam logic [XLEN-1:0] NARROW_W = XLEN'(2);

  logic [XLEN-1:0] insn_w;
  logic [XLEN-1:0] base;

  always_comb begin
    insn_w = status[T_BIT] ? NARROW_W : WIDE_W;
    base   = pc - insn_w;
    link   = (kind == KIND_IRQ) ? base + WIDE_W : base;
  end
endmodule

// File: rtl/exc_status_gen.sv
module exc_status_gen #(
  parameter int XLEN   = 32,
  parameter int MODE_W = 5,
  parameter int I_BIT  = 7,
  parameter int T_BIT  = 5
) (
  input  logic [XLEN-1:0]   status,
  input  logic [MODE_W-1:0] mode,
  output logic [XLEN-1:0]   new_status
);
  always_comb begin
    new_status               = status;
    new_status[MODE_W-1:0]   = mode;
    new_status[I_BIT]        = 1'b1;
    new_status[T_BIT]        = 1'b0;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              MODE_W   = 5,
  parameter int              I_BIT    = 7,
  parameter int              T_BIT    = 5,
  parameter logic [31:0]     VEC_SWI  = 32'h08,
  parameter logic [31:0]     VEC_IRQ  = 32'h18,
  parameter logic [4:0]      MODE_SVC = 5'h13,
  parameter logic [4:0]      MODE_IRQ = 5'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              swi_valid,
  output logic              swi_ready,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_status,
  output logic              ent_valid,
  output logic [XLEN-1:0]   ent_pc,
  output logic [XLEN-1:0]   ent_link,
  output logic [XLEN-1:0]   ent_saved,
  output logic [XLEN-1:0]   ent_status,
  output logic [MODE_W-1:0] ent_mode,
  output logic              mode_we,
  output logic              flush
);
  exc_kind_e         kind;
  logic [XLEN-1:0]   link_d;
  logic [XLEN-1:0]   status_d;
  logic [XLEN-1:0]   vec_d;
  logic [MODE_W-1:0] mode_d;
  logic              pulse_q;

  exc_arbiter u_arb (
    .irq_req   (irq_req),
    .irq_mask  (cur_status[I_BIT]),
    .swi_valid (swi_valid),
    .blocked   (pulse_q),
    .swi_ready (swi_ready),
    .kind      (kind)
  );

  always_comb begin
    if (kind == KIND_IRQ) begin
      mode_d = MODE_W'(MODE_IRQ);
      vec_d  = XLEN'(VEC_IRQ);
    end else begin
      mode_d = MODE_W'(MODE_SVC);
      vec_d  = XLEN'(VEC_SWI);
    end
  end

  exc_link_calc #(.XLEN(XLEN), .T_BIT(T_BIT)) u_link (
    .pc     (cur_pc),
    .status (cur_status),
    .kind   (kind),
    .link   (link_d)
  );

  exc_status_gen #(.XLEN(XLEN), .MODE_W(MODE_W), .I_BIT(I_BIT), .T_BIT(T_BIT)) u_stat (
    .status     (cur_status),
    .mode       (mode_d),
    .new_status (status_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q    <= 1'b0;
      ent_pc     <= '0;
      ent_link   <= '0;
      ent_saved  <= '0;
      ent_status <= '0;
      ent_mode   <= '0;
    end else begin
      pulse_q <= (kind != KIND_NONE);
      if (kind != KIND_NONE) begin
        ent_pc     <= vec_d;
        ent_link   <= link_d;
        ent_saved  <= cur_status;
        ent_status <= status_d;
        ent_mode   <= mode_d;
      end
    end
  end

  assign ent_valid = pulse_q;
  assign mode_we   = pulse_q;
  assign flush     = pulse_q;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic        swi_valid,
  input logic        swi_ready,
  input logic [31:0] cur_pc,
  input logic [31:0] cur_status,
  input logic        ent_valid,
  input logic [31:0] ent_pc,
  input logic [31:0] ent_link,
  input logic [31:0] ent_saved,
  input logic [31:0] ent_status,
  input logic [4:0]  ent_mode,
  input logic        mode_we,
  input logic        flush
);
  logic        swi_xfer;
  logic        irq_take;
  logic [31:0] wid;
  assign swi_xfer = swi_valid && swi_ready;
  assign irq_take = irq_req && !cur_status[7] && swi_ready && !swi_valid;
  assign wid      = cur_status[5] ? 32'd2 : 32'd4;

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cur_status[7] && !swi_xfer) |=> !ent_valid); // R3
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (ent_valid && ent_mode == 5'h12)); // R2
  AST_SWI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    swi_xfer |=> (ent_valid && ent_mode == 5'h13)); // R4
  AST_VECTOR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (ent_pc == ((ent_mode == 5'h12) ? 32'h18 : 32'h08))); // R2
  AST_STATUS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (ent_status[7] && !ent_status[5] && ent_status[4:0] == ent_mode)); // R7
  AST_SAVED_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_xfer || irq_take) |=> (ent_saved == $past(cur_status))); // R7
  AST_SWI_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    swi_xfer |=> (ent_link == $past(cur_pc) - $past(wid))); // R6
  AST_IRQ_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (ent_link == $past(cur_pc) - $past(wid) + 32'd4)); // R5
  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (!swi_ready ##1 !ent_valid)); // R9
  AST_PULSE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ent_valid) |-> (mode_we && flush)); // R10
endmodule

bind exc_entry_seq exc_entry_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_valid(swi_valid),
  .swi_ready(swi_ready), .cur_pc(cur_pc), .cur_status(cur_status),
  .ent_valid(ent_valid), .ent_pc(ent_pc), .ent_link(ent_link),
  .ent_saved(ent_saved), .ent_status(ent_status), .ent_mode(ent_mode),
  .mode_we(mode_we), .flush(flush)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic        swi_valid = 1'b0;
  logic        swi_ready;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_status = '0;
  logic        ent_valid;
  logic [31:0] ent_pc, ent_link, ent_saved, ent_status;
  logic [4:0]  ent_mode;
  logic        mode_we, flush;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .swi_valid(swi_valid),
    .swi_ready(swi_ready), .cur_pc(cur_pc), .cur_status(cur_status),
    .ent_valid(ent_valid), .ent_pc(ent_pc), .ent_link(ent_link),
    .ent_saved(ent_saved), .ent_status(ent_status), .ent_mode(ent_mode),
    .mode_we(mode_we), .flush(flush)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_entry(input string req, input bit is_irq, input logic [31:0] pc,
                           input logic [31:0] st);
    logic [31:0] w, exp_link, exp_st;
    logic [4:0]  m;
    w        = st[5] ? 32'd2 : 32'd4;
    m        = is_irq ? 5'h12 : 5'h13;
    exp_link = is_irq ? pc - w + 32'd4 : pc - w;
    exp_st   = st;
    exp_st[4:0] = m;
    exp_st[7] = 1'b1;
    exp_st[5] = 1'b0;
    chk({req, " valid"}, 32'(ent_valid), 32'd1);
    chk({req, " mode"}, 32'(ent_mode), 32'(m));
    chk({req, " vector"}, ent_pc, is_irq ? 32'h18 : 32'h08);
    chk(is_irq ? "R5 link" : "R6 link", ent_link, exp_link);
    chk("R7 saved", ent_saved, st);
    chk("R7 status", ent_status, exp_st);
    chk("R10 pulses", {30'd0, mode_we, flush}, 32'd3);
    chk("R9 ready low", 32'(swi_ready), 32'd0);
  endtask

  initial begin
    logic [31:0] pcs [4];
    pcs[0] = 32'h0000_0100; pcs[1] = 32'h0000_0002;
    pcs[2] = 32'h0000_0000; pcs[3] = 32'h8000_0006;
    step(); step();
    rst_n = 1'b1;
    chk("R1 valid", 32'(ent_valid), 32'd0);
    chk("R1 ready", 32'(swi_ready), 32'd1);
    chk("R1 payload", ent_pc | ent_link | ent_saved | ent_status | 32'(ent_mode), 32'd0);
    chk("R1 pulses", {30'd0, mode_we, flush}, 32'd0);

    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 2; t++)
        for (int ib = 0; ib < 2; ib++)
          for (int k = 0; k < 2; k++) begin
            logic [31:0] st;
            st = 32'hA000_0010 | (t != 0 ? 32'h20 : 32'h0) | (ib != 0 ? 32'h80 : 32'h0);
            cur_pc = pcs[p]; cur_status = st;
            irq_req = (k == 1); swi_valid = (k == 0);
            step();
            irq_req = 1'b0; swi_valid = 1'b0;
            if (k == 1 && ib != 0) begin
              chk("R3 masked", 32'(ent_valid), 32'd0);
              chk("R3 ready", 32'(swi_ready), 32'd1);
            end else begin
              chk_entry(k == 1 ? "R2" : "R4", k == 1, pcs[p], st);
              step();
              chk("R10 one-cycle", 32'(ent_valid), 32'd0);
            end
            step();
          end

    // R8: simultaneous requests
    cur_pc = 32'h0000_4000; cur_status = 32'h0000_0010;
    irq_req = 1'b1; swi_valid = 1'b1;
    step();
    swi_valid = 1'b0;
    chk_entry("R8 swi first", 1'b0, 32'h0000_4000, 32'h0000_0010);
    step();
    chk("R8 blocked", 32'(ent_valid), 32'd0);
    step();
    irq_req = 1'b0;
    chk_entry("R8 irq after", 1'b1, 32'h0000_4000, 32'h0000_0010);
    step(); step();

    // R9: held software request waits out the blocked cycle
    cur_pc = 32'h0000_0800; cur_status = 32'h0000_0030;
    swi_valid = 1'b1;
    step();
    chk_entry("R9 first", 1'b0, 32'h0000_0800, 32'h0000_0030);
    step();
    chk("R9 blocked", 32'(ent_valid), 32'd0);
    chk("R9 ready back", 32'(swi_ready), 32'd1);
    step();
    swi_valid = 1'b0;
    chk_entry("R9 second", 1'b0, 32'h0000_0800, 32'h0000_0030);
    step();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule